// File: doc/BRIEF.md
# Digital Soft Mute Ramp

This block fades a multi-channel stream of 24-bit signed audio samples in and out without a click. Each frame strobe delivers one sample for every channel on a packed bus. While the mute request is high, a shared gain walks down from unity to zero over a fixed number of frames. While the request is low, the gain walks back up to unity. All channels are scaled by the same gain, in the digital domain, ahead of any conversion.

The ramp length follows a 2-bit sampling speed mode, so the fade lasts the same wall-clock time at every sample rate. The gain runs on a single 4096-step scale. Each frame it moves by 4 steps in normal mode, by 2 in double mode and by 1 in quad mode. If the request flips while a ramp is under way, the gain turns around from the level it has reached. The ramp does not restart from an end point. A flag reports when the gain sits at full silence.

Top module: `soft_mute_ramp`

## Requirements
- R1: After synchronous reset the gain is unity (4096), `samples_out` is all zero and `muted` is 0.
- R2: Gain, `samples_out` and `muted` change only on a clock edge where `frame_stb` is high. Input changes without a strobe have no effect on the outputs.
- R3: With `speed_mode` 2'b00 (normal), a mute request held from unity sets `muted` on exactly the 1024th strobe.
- R4: `speed_mode` 2'b01 (double) takes 2048 strobes and 2'b10 (quad) takes 4096 strobes from unity to silence. 2'b11 behaves as normal (1024).
- R5: Once the request is released, the gain climbs back to unity in the same number of strobes as the descent for that mode. The gain never rises while muting and never falls while unmuting.
- R6: A release part way down reverses from the level reached. After N descending normal-mode strobes from unity, N ascending normal-mode strobes restore unity.
- R7: On each strobe, lane c of `samples_out` (bits [c*24 +: 24]) becomes floor(x*g/4096). Here x is lane c of `samples_in` and g is the gain after that strobe's update. At unity the output equals the input exactly, including 24'h7FFFFF and 24'h800000.
- R8: While the gain is zero, every lane of `samples_out` is exactly 0.
- R9: `muted` is 1 exactly when the gain is zero.
- R10: All channels share one gain. Each lane is scaled independently of the other lanes' data.
- R11: Each step is clamped at 0 and at 4096, so a mode change mid-ramp cannot overshoot. For example, from 4093, normal-mode muting reaches 0 after 1024 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle strobe, one per frame |
| mute_req | input | 1 | 1 ramps the gain toward silence, 0 ramps it toward unity |
| speed_mode | input | 2 | 00 normal, 01 double, 10 quad, 11 as normal |
| samples_in | input | CH*W (192) | Packed signed samples, lane c at [c*W +: W] |
| samples_out | output | CH*W (192) | Scaled samples, registered on the strobe |
| muted | output | 1 | High while the gain is zero |

## Verification
The hardest conditions to reach are the gain levels that the step sizes never visit from unity. One example is a gain left at an odd value by quad steps, then driven by 4-step normal ramps until it clamps at an end point. Another is a reversal from an arbitrary level in the middle of a ramp. The stimulus reaches these conditions in two ways. First, it issues a few quad-mode strobes and then switches the mode mid-ramp. Second, it releases the request after a chosen number of descending frames. In both cases it counts the strobes until `muted` rises, or until full-scale input passes through unchanged. Every frame in between is checked lane by lane against an independently kept gain.

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int CH        = 8,
  parameter int W         = 24,
  parameter int RAMP_LOG2 = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_stb,
  input  logic            mute_req,
  input  logic [1:0]      speed_mode,
  input  logic [CH*W-1:0] samples_in,
  output logic [CH*W-1:0] samples_out,
  output logic            muted
);

  localparam int            GW    = RAMP_LOG2 + 1;
  localparam int            PW    = W + GW + 1;
  localparam logic [GW-1:0] UNITY = GW'(1) << RAMP_LOG2;

  logic [GW-1:0]   gain, gain_nxt, step, room;
  logic [CH*W-1:0] scaled;

  assign step = (speed_mode == 2'b10) ? GW'(1) :
                (speed_mode == 2'b01) ? GW'(2) : GW'(4);
  assign room = UNITY - gain;

  assign gain_nxt = mute_req ? ((gain > step) ? gain - step : '0)
                             : ((room > step) ? gain + step : UNITY);

  always_ff @(posedge clk) begin
    if (rst)            gain <= UNITY;
    else if (frame_stb) gain <= gain_nxt;
  end

  assign muted = (gain == '0);

  for (genvar c = 0; c < CH; c++) begin : g_lane
    logic signed [PW-1:0] sx, gx, prod;
    assign sx   = {{(PW-W){samples_in[c*W+W-1]}}, samples_in[c*W +: W]};
    assign gx   = {{(PW-GW){1'b0}}, gain_nxt};
    assign prod = sx * gx;
    assign scaled[c*W +: W] = W'(prod >>> RAMP_LOG2);
  end

  always_ff @(posedge clk) begin
    if (rst)            samples_out <= '0;
    else if (frame_stb) samples_out <= scaled;
  end

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(gain) && $stable(samples_out) && $stable(muted));

  a_r11_gain_in_range: assert property (@(posedge clk) disable iff (rst)
    gain <= UNITY);

  a_r4_step_bounded: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> ((gain - $past(gain)) <= GW'(4)) || (($past(gain) - gain) <= GW'(4)));

  a_r5_no_fall_when_released: assert property (@(posedge clk) disable iff (rst)
    frame_stb && !mute_req |=> gain >= $past(gain));

  a_r6_no_rise_when_muting: assert property (@(posedge clk) disable iff (rst)
    frame_stb && mute_req |=> gain <= $past(gain));

  a_r8_silent_when_muted: assert property (@(posedge clk) disable iff (rst)
    muted |-> samples_out == '0);

endmodule

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;
  localparam int CH = 8;
  localparam int W = 24;
  localparam int UNITY = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic mreq = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [CH*W-1:0] din = '0;
  logic [CH*W-1:0] dout;
  logic muted;

  int total = 0;
  int bad = 0;
  int g_model = UNITY;
  int frame_no = 0;
  logic stb_d = 1'b0;
  logic [CH*W-1:0] q_data[$];
  logic q_mute[$];

  soft_mute_ramp #(.CH(CH), .W(W), .RAMP_LOG2(12)) i_soft_mute_ramp (
    .clk(clk), .rst(rst), .frame_stb(stb), .mute_req(mreq),
    .speed_mode(mode), .samples_in(din), .samples_out(dout), .muted(muted));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int f, input int c);
    case (c)
      0: return 24'h7FFFFF;
      1: return 24'h800000;
      2: return 24'h000000;
      default: return W'((f * 40503 + c * 19088743) ^ (f << 7));
    endcase
  endfunction

  function automatic logic [W-1:0] scale(input logic [W-1:0] s, input int g);
    longint p;
    p = longint'($signed(s)) * longint'(g);
    return W'(p >>> 12);
  endfunction

  always @(posedge clk) stb_d <= stb;

  always @(negedge clk) begin
    if (stb_d) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R7 scoreboard empty", 0, 1);
      end else begin
        logic [CH*W-1:0] e;
        logic em;
        e = q_data.pop_front();
        em = q_mute.pop_front();
        for (int c = 0; c < CH; c++)
          chk(dout[c*W +: W] == e[c*W +: W], "R7/R10 lane value", dout[c*W +: W], e[c*W +: W]);
        chk(muted == em, "R9 muted flag", muted, em);
      end
    end
  end

  task automatic send(input bit m, input logic [1:0] md);
    int st;
    logic [CH*W-1:0] d, e;
    @(negedge clk);
    st = (md == 2'b10) ? 1 : (md == 2'b01) ? 2 : 4;
    if (m) g_model = (g_model > st) ? g_model - st : 0;
    else   g_model = (UNITY - g_model > st) ? g_model + st : UNITY;
    for (int c = 0; c < CH; c++) begin
      d[c*W +: W] = pattern(frame_no, c);
      e[c*W +: W] = scale(d[c*W +: W], g_model);
    end
    q_data.push_back(e);
    q_mute.push_back(g_model == 0);
    mreq = m; mode = md; din = d; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    frame_no++;
    #1;
  endtask

  task automatic run_to_mute(input logic [1:0] md, output int n);
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      send(1'b1, md);
      n++;
      if (muted) break;
    end
  endtask

  task automatic run_to_unity(input logic [1:0] md, output int n);
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      send(1'b0, md);
      n++;
      if (dout[W-1:0] == 24'h7FFFFF) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [CH*W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(dout == '0, "R1 reset output", dout[W-1:0], 0);
    chk(muted == 1'b0, "R1 reset muted", muted, 0);

    for (int k = 0; k < 4; k++) send(1'b0, 2'b00);
    chk(dout[W-1:0] == 24'h7FFFFF && dout[2*W-1:W] == 24'h800000, "R7 unity passthrough",
        dout[2*W-1:0], {24'h800000, 24'h7FFFFF});

    held = dout;
    @(negedge clk);
    din = ~din; mreq = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk(dout == held, "R2 no strobe hold", dout[W-1:0], held[W-1:0]);
    chk(muted == 1'b0, "R2 muted hold", muted, 0);

    run_to_mute(2'b00, n);
    chk(n == 1024, "R3 normal ramp length", n, 1024);
    for (int k = 0; k < 3; k++) send(1'b1, 2'b00);
    chk(dout == '0, "R8 silent at zero gain", dout[W-1:0], 0);

    run_to_unity(2'b00, n);
    chk(n == 1024, "R5 normal release length", n, 1024);

    run_to_mute(2'b01, n);
    chk(n == 2048, "R4 double ramp length", n, 2048);
    run_to_unity(2'b01, n);
    chk(n == 2048, "R5 double release length", n, 2048);

    run_to_mute(2'b10, n);
    chk(n == 4096, "R4 quad ramp length", n, 4096);
    run_to_unity(2'b11, n);
    chk(n == 1024, "R4 mode 11 as normal", n, 1024);

    for (int k = 0; k < 300; k++) send(1'b1, 2'b00);
    chk(muted == 1'b0, "R6 partial not muted", muted, 0);
    run_to_unity(2'b00, n);
    chk(n == 300, "R6 reversal from level", n, 300);

    for (int k = 0; k < 3; k++) send(1'b1, 2'b10);
    run_to_mute(2'b00, n);
    chk(n == 1024, "R11 clamp at zero", n, 1024);
    for (int k = 0; k < 5; k++) send(1'b0, 2'b10);
    run_to_unity(2'b00, n);
    chk(n == 1023, "R11 clamp at unity", n, 1023);

    repeat (3) @(negedge clk);
    chk(q_data.size() == 0, "R7 scoreboard drained", q_data.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule